// File: doc/BRIEF.md
# Calendar Alarm Matcher

This block watches a running calendar, presented to it as BCD fields, and raises an alarm interrupt when the time matches a programmed alarm. A time-keeping block elsewhere supplies the current seconds, minutes, hours, day of month, month and three-digit year, together with a strobe that pulses once per second when those fields advance. The matcher holds one alarm value for each field and a control word. The control word has one enable bit per field and one master enable.

The per-field enables combine with OR. On a second strobe with the master enable set, any single enabled field that equals its stored value fires the alarm. The alarm is recorded in a sticky status bit that drives the interrupt line directly. Software clears it by writing a one to that bit. A small register port with an address, a write strobe and a combinational read path gives access to the alarm fields, the control word and the status.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, every register address reads 0 and `alarm_irq` is low.
- R2: Address map: 0 status, 1 control, 2 seconds, 3 minutes, 4 hours, 5 day of month, 6 month, 7 year. Control bits: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 master enable. The control register keeps bits 6:0 and reads them back as written.
- R3: A match is evaluated only in a cycle with `sec_tick` high and control bit 6 set. With `sec_tick` low or bit 6 clear, no alarm is raised.
- R4: On an evaluating strobe, the alarm fires if at least one enabled field equals its stored value (OR across fields). With no field enabled, it never fires.
- R5: Stored fields are masked on write and read back masked: seconds and minutes to 7 bits, hours and day to 6 bits, month to 5 bits, year to 12 bits.
- R6: A match sets status bit 1 and raises `alarm_irq` from the next cycle. Both stay set until cleared.
- R7: A write to address 0 with bit 1 set clears status bit 1 and lowers `alarm_irq`. A write to address 0 with bit 1 clear has no effect.
- R8: When a match and a clearing write fall in the same cycle, the status stays set.
- R9: Fields are compared as raw BCD codes. A current seconds value of 0x45 matches a stored 0x45 but does not match 0x44.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| sec_tick | input | 1 | One-second update strobe |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_mday | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| now_year | input | 12 | Current year, three BCD digits |
| alarm_irq | output | 1 | Alarm interrupt, level, sticky |

## Verification
The bench builds the block with its defaults, a 16-bit data path and a 3-bit address. With those defaults, every register is reachable. The control space is small enough to sweep in full: all 128 control words are crossed with all 64 patterns of matching and non-matching fields, so each OR combination and the master gate are each checked against an arithmetic expectation. Masking is checked by writing all ones to each field and reading back. The remaining cycle-level cases are checked directed: no strobe, a same-cycle set and clear, and a status write with bit 1 clear.

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sec_tick,
  input  logic [7:0]        now_sec,
  input  logic [7:0]        now_min,
  input  logic [7:0]        now_hour,
  input  logic [7:0]        now_mday,
  input  logic [7:0]        now_mon,
  input  logic [11:0]       now_year,
  output logic              alarm_irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DAY  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(7);
  localparam int MASTER = 6;

  logic [6:0]  ctrl_q;
  logic [6:0]  sec_q, min_q;
  logic [5:0]  hour_q, day_q;
  logic [4:0]  mon_q;
  logic [11:0] year_q;
  logic        stat_q;
  logic [5:0]  eq;
  logic        fire, clr;

  assign eq[0] = now_sec  == {1'b0, sec_q};
  assign eq[1] = now_min  == {1'b0, min_q};
  assign eq[2] = now_hour == {2'b0, hour_q};
  assign eq[3] = now_mday == {2'b0, day_q};
  assign eq[4] = now_mon  == {3'b0, mon_q};
  assign eq[5] = now_year == year_q;

  assign fire = sec_tick && ctrl_q[MASTER] && |(eq & ctrl_q[5:0]);
  assign clr  = reg_we && reg_addr == A_STAT && reg_wdata[1];
  assign alarm_irq = stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; sec_q <= '0; min_q <= '0; hour_q <= '0;
      day_q <= '0; mon_q <= '0; year_q <= '0; stat_q <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_CTRL: ctrl_q <= reg_wdata[6:0];
          A_SEC:  sec_q  <= reg_wdata[6:0];
          A_MIN:  min_q  <= reg_wdata[6:0];
          A_HOUR: hour_q <= reg_wdata[5:0];
          A_DAY:  day_q  <= reg_wdata[5:0];
          A_MON:  mon_q  <= reg_wdata[4:0];
          A_YEAR: year_q <= reg_wdata[11:0];
          default: ;
        endcase
      end
      if (fire)     stat_q <= 1'b1;
      else if (clr) stat_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT: reg_rdata[1] = stat_q;
      A_CTRL: reg_rdata[6:0] = ctrl_q;
      A_SEC:  reg_rdata[6:0] = sec_q;
      A_MIN:  reg_rdata[6:0] = min_q;
      A_HOUR: reg_rdata[5:0] = hour_q;
      A_DAY:  reg_rdata[5:0] = day_q;
      A_MON:  reg_rdata[4:0] = mon_q;
      A_YEAR: reg_rdata[11:0] = year_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/cal_alarm_match_chk.sv
module cal_alarm_match_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              sec_tick,
  input logic [6:0]        ctrl_q,
  input logic              fire,
  input logic              alarm_irq
);
  logic clr_wr;
  assign clr_wr = reg_we && reg_addr == '0 && reg_wdata[1];

  assert_no_fire_without_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !alarm_irq) |=> !alarm_irq);

  assert_no_fire_master_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[6] && !alarm_irq) |=> !alarm_irq);

  assert_match_raises_irq_R6: assert property (@(posedge clk) disable iff (rst)
    fire |=> alarm_irq);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (alarm_irq && !clr_wr) |=> alarm_irq);

  assert_clear_lowers_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !fire) |=> !alarm_irq);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && fire) |=> alarm_irq);
endmodule

bind cal_alarm_match cal_alarm_match_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .sec_tick(sec_tick), .ctrl_q(ctrl_q), .fire(fire), .alarm_irq(alarm_irq)
);

// File: tb/test_cal_alarm_match.sv
`timescale 1ns/1ps
module test_cal_alarm_match;
  localparam int DW = 16;
  localparam int AW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic sec_tick = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_mday = '0, now_mon = '0;
  logic [11:0] now_year = '0;
  logic alarm_irq;
  int vec = 0, bad = 0;

  always #5 clk = ~clk;

  cal_alarm_match #(.DATA_W(DW), .ADDR_W(AW)) i_cal_alarm_match (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sec_tick(sec_tick), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_mday(now_mday), .now_mon(now_mon), .now_year(now_year),
    .alarm_irq(alarm_irq));

  localparam logic [7:0]  S_SEC = 8'h45, S_MIN = 8'h30, S_HOUR = 8'h12, S_DAY = 8'h28, S_MON = 8'h11;
  localparam logic [11:0] S_YEAR = 12'h123;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic set_now(input logic [5:0] pat);
    now_sec  = pat[0] ? S_SEC  : S_SEC  ^ 8'h01;
    now_min  = pat[1] ? S_MIN  : S_MIN  ^ 8'h01;
    now_hour = pat[2] ? S_HOUR : S_HOUR ^ 8'h01;
    now_mday = pat[3] ? S_DAY  : S_DAY  ^ 8'h01;
    now_mon  = pat[4] ? S_MON  : S_MON  ^ 8'h01;
    now_year = pat[5] ? S_YEAR : S_YEAR ^ 12'h001;
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      check("R1", d, '0);
    end
    check("R1", DW'(alarm_irq), '0);

    // R5 masking and readback
    wr(2, 16'hFFFF); rd(2, d); check("R5", d, 16'h007F);
    wr(3, 16'hFFFF); rd(3, d); check("R5", d, 16'h007F);
    wr(4, 16'hFFFF); rd(4, d); check("R5", d, 16'h003F);
    wr(5, 16'hFFFF); rd(5, d); check("R5", d, 16'h003F);
    wr(6, 16'hFFFF); rd(6, d); check("R5", d, 16'h001F);
    wr(7, 16'hFFFF); rd(7, d); check("R5", d, 16'h0FFF);
    wr(1, 16'hFFFF); rd(1, d); check("R2", d, 16'h007F);

    wr(2, DW'(S_SEC)); wr(3, DW'(S_MIN)); wr(4, DW'(S_HOUR));
    wr(5, DW'(S_DAY)); wr(6, DW'(S_MON)); wr(7, DW'(S_YEAR));

    // R3: match present, no strobe -> no alarm
    wr(1, 16'h007F);
    set_now(6'h3F);
    repeat (4) @(negedge clk);
    check("R3", DW'(alarm_irq), '0);

    // R2, R3, R4 exhaustive sweep of control word x match pattern
    for (int m = 0; m < 128; m++) begin
      wr(1, DW'(m));
      rd(1, d);
      check("R2", d, DW'(m));
      for (int p = 0; p < 64; p++) begin
        logic exp;
        set_now(6'(p));
        tick();
        exp = m[6] && ((m[5:0] & p[5:0]) != 0);
        check("R4", DW'(alarm_irq), DW'(exp));
        rd(0, d);
        check("R6", d, DW'({exp, 1'b0}));
        if (exp) wr(0, 16'h0002);
      end
    end

    // R9: raw BCD compare of seconds
    wr(1, 16'h0041);
    now_sec = 8'h45; tick();
    check("R9", DW'(alarm_irq), 1);
    wr(0, 16'h0002);
    check("R7", DW'(alarm_irq), 0);
    wr(2, 16'h0044);
    tick();
    check("R9", DW'(alarm_irq), 0);
    wr(2, DW'(S_SEC));

    // R6 sticky across later non-matching strobes
    tick();
    now_sec = 8'h00;
    repeat (3) tick();
    check("R6", DW'(alarm_irq), 1);

    // R7: write with bit 1 clear has no effect
    wr(0, 16'hFFFD);
    check("R7", DW'(alarm_irq), 1);
    rd(0, d); check("R7", d, 16'h0002);
    wr(0, 16'h0002);
    rd(0, d); check("R7", d, 16'h0000);

    // R8: set wins over same-cycle clear
    now_sec = S_SEC;
    tick();
    check("R8", DW'(alarm_irq), 1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = '0; reg_wdata = 16'h0002; sec_tick = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; sec_tick = 1'b0;
    check("R8", DW'(alarm_irq), 1);
    wr(0, 16'h0002);
    check("R7", DW'(alarm_irq), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule